// File: doc/BRIEF.md
# Programmable panel timing generator

This block produces the three timing strobes that a flat panel needs: a vertical sync, a horizontal sync and a data-enable qualifier. A pixel counter and a line counter both run on the output pixel clock. The pixel counter counts through the programmed line length. Each time it wraps, the line counter steps, and it counts through the programmed frame height. The two counters are also exported. Every strobe edge is a position compared against these counters. Each strobe has its own polarity bit.

Horizontal sync and data enable are per-line windows on the pixel counter. Vertical sync is placed at pixel resolution: it rises at a chosen pixel of line 0 and falls at a chosen pixel of a chosen end line. It is tracked by a three-state sequencer with these states:
- `VS_WAIT`: before the start point.
- `VS_ACTIVE`: inside the pulse.
- `VS_DONE`: after the end point.

The sequencer has four transitions:
- arm: from `VS_WAIT` to `VS_ACTIVE` at the start point.
- skip: from `VS_WAIT` to `VS_DONE` when the end point does not follow the start point.
- disarm: from `VS_ACTIVE` to `VS_DONE` at the end point.
- rearm: from any state back to `VS_WAIT` or `VS_ACTIVE` at the frame boundary.

A control bit can blank data enable for the whole vertical sync pulse. All configuration is copied into a shadow set at reset and at each frame boundary. A change made mid-frame therefore only applies from the next frame.

Top module: `panel_timing_gen`

## Requirements
- R1: The pixel count runs 0 to h_total-1 and then returns to 0. Each return steps the line count, which runs 0 to v_total-1 and then returns to 0.
- R2: Each output has its own polarity bit. With the bit at 1 the output is high when active. With the bit at 0 it is low when active.
- R3: Horizontal sync is active on every line for pixels p with hs_on <= p < hs_off. When hs_on >= hs_off there is no pulse.
- R4: Vertical sync becomes active at pixel vs_on_pix of line 0. It stays active until pixel vs_off_pix of line vs_off_line, where it is already inactive.
- R5: A vertical sync that starts and ends within line 0 is honoured. When the end point does not come after the start point, there is no vertical sync at all.
- R6: Data enable is active on every line for pixels p with de_on <= p < de_off. When de_on >= de_off there is no pulse.
- R7: With cfg_de_in_vs = 0, data enable is forced inactive wherever vertical sync is active. With cfg_de_in_vs = 1, the two are independent.
- R8: The outputs are registered. In each cycle they show the decoded state of the counter position held one clock earlier.
- R9: While the synchronous reset is applied, both counts are 0 and every output sits at its inactive level for its polarity bit.
- R10: Configuration written mid-frame, including h_total and v_total, is ignored until the counters next reach line 0, pixel 0. From then on it governs the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_h_total | input | PIX_W | Pixels per line |
| cfg_v_total | input | LINE_W | Lines per frame |
| cfg_hs_on | input | PIX_W | First pixel of horizontal sync |
| cfg_hs_off | input | PIX_W | First pixel after horizontal sync |
| cfg_vs_on_pix | input | PIX_W | Pixel in line 0 where vertical sync starts |
| cfg_vs_off_line | input | LINE_W | Line in which vertical sync ends |
| cfg_vs_off_pix | input | PIX_W | Pixel in the end line where vertical sync is already off |
| cfg_de_on | input | PIX_W | First pixel of data enable |
| cfg_de_off | input | PIX_W | First pixel after data enable |
| cfg_pol_vs | input | 1 | Vertical sync polarity, 1 = active high |
| cfg_pol_hs | input | 1 | Horizontal sync polarity, 1 = active high |
| cfg_pol_de | input | 1 | Data enable polarity, 1 = active high |
| cfg_de_in_vs | input | 1 | 1 = data enable allowed during vertical sync |
| vs_o | output | 1 | Vertical sync |
| hs_o | output | 1 | Horizontal sync |
| de_o | output | 1 | Data enable |
| pix_cnt_o | output | PIX_W | Current pixel count |
| line_cnt_o | output | LINE_W | Current line count |

## Verification
The counts change on the same rising edge that the bench models. The three strobes show the position held one rising edge earlier. The bench therefore works out the expected strobe levels from its model position just before each rising edge. It samples the counts and the strobes together at the following falling edge.

Configuration is changed at a falling edge. The bench model adopts the new values only at the rising edge where its own position returns to line 0, pixel 0. This is the same edge at which the design copies them. A mid-frame change is thus checked both for being ignored in the rest of the old frame and for taking hold in the new frame.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    // Region of the vertical sync pulse relative to the current position
    typedef enum logic [1:0] {
        VS_WAIT   = 2'd0,
        VS_ACTIVE = 2'd1,
        VS_DONE   = 2'd2
    } vs_state_e;

    // Number of per-line pixel windows and their slots
    localparam int unsigned NUM_WIN = 2;
    localparam int unsigned WIN_HS  = 0;
    localparam int unsigned WIN_DE  = 1;

endpackage

// File: rtl/ptg_counters.sv
module ptg_counters #(
    parameter int unsigned PIX_W  = 12,
    parameter int unsigned LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIX_W-1:0]  h_total,
    input  logic [LINE_W-1:0] v_total,
    output logic [PIX_W-1:0]  pix,
    output logic [LINE_W-1:0] ln,
    output logic [PIX_W-1:0]  nxt_pix,
    output logic [LINE_W-1:0] nxt_ln,
    output logic              frame_start
);

    logic line_end;
    logic frame_end;

    // Next position, computed once and shared with the sync sequencer
    always_comb begin
        line_end    = (pix >= h_total - PIX_W'(1));
        frame_end   = (ln >= v_total - LINE_W'(1));
        nxt_pix     = line_end ? '0 : pix + PIX_W'(1);
        if (line_end) begin
            nxt_ln = frame_end ? '0 : ln + LINE_W'(1);
        end else begin
            nxt_ln = ln;
        end
        frame_start = line_end && frame_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix <= '0;
            ln  <= '0;
        end else begin
            pix <= nxt_pix;
            ln  <= nxt_ln;
        end
    end

endmodule

// File: rtl/ptg_cfg_shadow.sv
module ptg_cfg_shadow #(
    parameter int unsigned PIX_W  = 12,
    parameter int unsigned LINE_W = 11
) (
    input  logic              clk,
    input  logic              load,
    input  logic [PIX_W-1:0]  in_h_total,
    input  logic [LINE_W-1:0] in_v_total,
    input  logic [PIX_W-1:0]  in_hs_on,
    input  logic [PIX_W-1:0]  in_hs_off,
    input  logic [PIX_W-1:0]  in_vs_on_pix,
    input  logic [LINE_W-1:0] in_vs_off_line,
    input  logic [PIX_W-1:0]  in_vs_off_pix,
    input  logic [PIX_W-1:0]  in_de_on,
    input  logic [PIX_W-1:0]  in_de_off,
    input  logic              in_pol_vs,
    input  logic              in_pol_hs,
    input  logic              in_pol_de,
    input  logic              in_de_in_vs,
    output logic [PIX_W-1:0]  sh_h_total,
    output logic [LINE_W-1:0] sh_v_total,
    output logic [PIX_W-1:0]  sh_hs_on,
    output logic [PIX_W-1:0]  sh_hs_off,
    output logic [PIX_W-1:0]  sh_de_on,
    output logic [PIX_W-1:0]  sh_de_off,
    output logic              sh_pol_vs,
    output logic              sh_pol_hs,
    output logic              sh_pol_de,
    output logic              sh_de_in_vs,
    output logic [PIX_W-1:0]  nx_vs_on_pix,
    output logic [LINE_W-1:0] nx_vs_off_line,
    output logic [PIX_W-1:0]  nx_vs_off_pix
);

    logic [PIX_W-1:0]  sh_vs_on_pix;
    logic [LINE_W-1:0] sh_vs_off_line;
    logic [PIX_W-1:0]  sh_vs_off_pix;

    // Copy the whole set only at reset or at the frame boundary
    always_ff @(posedge clk) begin
        if (load) begin
            sh_h_total     <= in_h_total;
            sh_v_total     <= in_v_total;
            sh_hs_on       <= in_hs_on;
            sh_hs_off      <= in_hs_off;
            sh_vs_on_pix   <= in_vs_on_pix;
            sh_vs_off_line <= in_vs_off_line;
            sh_vs_off_pix  <= in_vs_off_pix;
            sh_de_on       <= in_de_on;
            sh_de_off      <= in_de_off;
            sh_pol_vs      <= in_pol_vs;
            sh_pol_hs      <= in_pol_hs;
            sh_pol_de      <= in_pol_de;
            sh_de_in_vs    <= in_de_in_vs;
        end
    end

    // The sequencer judges the next position, so on a load edge it must
    // already see the values that will govern that position
    always_comb begin
        nx_vs_on_pix   = load ? in_vs_on_pix   : sh_vs_on_pix;
        nx_vs_off_line = load ? in_vs_off_line : sh_vs_off_line;
        nx_vs_off_pix  = load ? in_vs_off_pix  : sh_vs_off_pix;
    end

endmodule

// File: rtl/ptg_window.sv
module ptg_window #(
    parameter int unsigned PIX_W = 12
) (
    input  logic [PIX_W-1:0] pos,
    input  logic [PIX_W-1:0] on_pos,
    input  logic [PIX_W-1:0] off_pos,
    output logic             active
);

    // Inclusive start, exclusive end; an empty or reversed range never fires
    always_comb begin
        active = (pos >= on_pos) && (pos < off_pos);
    end

endmodule

// File: rtl/ptg_vs_fsm.sv
module ptg_vs_fsm
    import ptg_pkg::*;
#(
    parameter int unsigned PIX_W  = 12,
    parameter int unsigned LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIX_W-1:0]  nxt_pix,
    input  logic [LINE_W-1:0] nxt_ln,
    input  logic              frame_start,
    input  logic [PIX_W-1:0]  on_pix,
    input  logic [LINE_W-1:0] off_line,
    input  logic [PIX_W-1:0]  off_pix,
    output vs_state_e         state,
    output logic              vs_active
);

    vs_state_e state_nxt;
    vs_state_e arm_tgt;
    logic      hit_on;
    logic      hit_off;
    logic      ordered;

    always_comb begin
        hit_on  = (nxt_ln == '0) && (nxt_pix == on_pix);
        hit_off = (nxt_ln == off_line) && (nxt_pix == off_pix);
        ordered = (off_line != '0) || (off_pix > on_pix);
        // arm goes to ACTIVE; skip goes straight to DONE
        arm_tgt = ordered ? VS_ACTIVE : VS_DONE;
    end

    // Transitions: arm/skip, disarm, rearm
    always_comb begin
        state_nxt = state;
        unique case (state)
            VS_WAIT: begin
                if (hit_on) begin
                    state_nxt = arm_tgt;
                end
            end
            VS_ACTIVE: begin
                if (frame_start) begin
                    state_nxt = hit_on ? arm_tgt : VS_WAIT;
                end else if (hit_off) begin
                    state_nxt = VS_DONE;
                end
            end
            VS_DONE: begin
                if (frame_start) begin
                    state_nxt = hit_on ? arm_tgt : VS_WAIT;
                end
            end
            default: begin
                state_nxt = VS_WAIT;
            end
        endcase
    end

    // State register: the reset position is line 0, pixel 0
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ((on_pix == '0) && ordered) ? VS_ACTIVE : VS_WAIT;
        end else begin
            state <= state_nxt;
        end
    end

    // Output decode
    always_comb begin
        vs_active = (state == VS_ACTIVE);
    end

endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
    import ptg_pkg::*;
#(
    parameter int unsigned PIX_W  = 12,
    parameter int unsigned LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIX_W-1:0]  cfg_h_total,
    input  logic [LINE_W-1:0] cfg_v_total,
    input  logic [PIX_W-1:0]  cfg_hs_on,
    input  logic [PIX_W-1:0]  cfg_hs_off,
    input  logic [PIX_W-1:0]  cfg_vs_on_pix,
    input  logic [LINE_W-1:0] cfg_vs_off_line,
    input  logic [PIX_W-1:0]  cfg_vs_off_pix,
    input  logic [PIX_W-1:0]  cfg_de_on,
    input  logic [PIX_W-1:0]  cfg_de_off,
    input  logic              cfg_pol_vs,
    input  logic              cfg_pol_hs,
    input  logic              cfg_pol_de,
    input  logic              cfg_de_in_vs,
    output logic              vs_o,
    output logic              hs_o,
    output logic              de_o,
    output logic [PIX_W-1:0]  pix_cnt_o,
    output logic [LINE_W-1:0] line_cnt_o
);

    logic [PIX_W-1:0]  pix;
    logic [LINE_W-1:0] ln;
    logic [PIX_W-1:0]  nxt_pix;
    logic [LINE_W-1:0] nxt_ln;
    logic              frame_start;
    logic              shadow_load;

    logic [PIX_W-1:0]  sh_h_total;
    logic [LINE_W-1:0] sh_v_total;
    logic [PIX_W-1:0]  sh_hs_on;
    logic [PIX_W-1:0]  sh_hs_off;
    logic [PIX_W-1:0]  sh_de_on;
    logic [PIX_W-1:0]  sh_de_off;
    logic              sh_pol_vs;
    logic              sh_pol_hs;
    logic              sh_pol_de;
    logic              sh_de_in_vs;
    logic [PIX_W-1:0]  nx_vs_on_pix;
    logic [LINE_W-1:0] nx_vs_off_line;
    logic [PIX_W-1:0]  nx_vs_off_pix;

    vs_state_e         vs_state;
    logic              vs_act;
    logic              de_act;

    logic [NUM_WIN-1:0][PIX_W-1:0] win_on;
    logic [NUM_WIN-1:0][PIX_W-1:0] win_off;
    logic [NUM_WIN-1:0]            win_act;

    ptg_counters #(
        .PIX_W (PIX_W),
        .LINE_W(LINE_W)
    ) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .h_total    (sh_h_total),
        .v_total    (sh_v_total),
        .pix        (pix),
        .ln         (ln),
        .nxt_pix    (nxt_pix),
        .nxt_ln     (nxt_ln),
        .frame_start(frame_start)
    );

    assign shadow_load = rst || frame_start;

    ptg_cfg_shadow #(
        .PIX_W (PIX_W),
        .LINE_W(LINE_W)
    ) u_shadow (
        .clk           (clk),
        .load          (shadow_load),
        .in_h_total    (cfg_h_total),
        .in_v_total    (cfg_v_total),
        .in_hs_on      (cfg_hs_on),
        .in_hs_off     (cfg_hs_off),
        .in_vs_on_pix  (cfg_vs_on_pix),
        .in_vs_off_line(cfg_vs_off_line),
        .in_vs_off_pix (cfg_vs_off_pix),
        .in_de_on      (cfg_de_on),
        .in_de_off     (cfg_de_off),
        .in_pol_vs     (cfg_pol_vs),
        .in_pol_hs     (cfg_pol_hs),
        .in_pol_de     (cfg_pol_de),
        .in_de_in_vs   (cfg_de_in_vs),
        .sh_h_total    (sh_h_total),
        .sh_v_total    (sh_v_total),
        .sh_hs_on      (sh_hs_on),
        .sh_hs_off     (sh_hs_off),
        .sh_de_on      (sh_de_on),
        .sh_de_off     (sh_de_off),
        .sh_pol_vs     (sh_pol_vs),
        .sh_pol_hs     (sh_pol_hs),
        .sh_pol_de     (sh_pol_de),
        .sh_de_in_vs   (sh_de_in_vs),
        .nx_vs_on_pix  (nx_vs_on_pix),
        .nx_vs_off_line(nx_vs_off_line),
        .nx_vs_off_pix (nx_vs_off_pix)
    );

    ptg_vs_fsm #(
        .PIX_W (PIX_W),
        .LINE_W(LINE_W)
    ) u_vs (
        .clk        (clk),
        .rst        (rst),
        .nxt_pix    (nxt_pix),
        .nxt_ln     (nxt_ln),
        .frame_start(frame_start),
        .on_pix     (nx_vs_on_pix),
        .off_line   (nx_vs_off_line),
        .off_pix    (nx_vs_off_pix),
        .state      (vs_state),
        .vs_active  (vs_act)
    );

    // Per-line pixel windows for horizontal sync and data enable
    always_comb begin
        win_on[WIN_HS]  = sh_hs_on;
        win_off[WIN_HS] = sh_hs_off;
        win_on[WIN_DE]  = sh_de_on;
        win_off[WIN_DE] = sh_de_off;
    end

    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
        ptg_window #(
            .PIX_W(PIX_W)
        ) u_win (
            .pos    (pix),
            .on_pos (win_on[gi]),
            .off_pos(win_off[gi]),
            .active (win_act[gi])
        );
    end

    always_comb begin
        de_act = win_act[WIN_DE] && (sh_de_in_vs || !vs_act);
    end

    // Registered outputs, polarity applied on the way in
    always_ff @(posedge clk) begin
        if (rst) begin
            vs_o <= ~cfg_pol_vs;
            hs_o <= ~cfg_pol_hs;
            de_o <= ~cfg_pol_de;
        end else begin
            vs_o <= ~(vs_act ^ sh_pol_vs);
            hs_o <= ~(win_act[WIN_HS] ^ sh_pol_hs);
            de_o <= ~(de_act ^ sh_pol_de);
        end
    end

    assign pix_cnt_o  = pix;
    assign line_cnt_o = ln;

endmodule

// File: rtl/ptg_checker.sv
module ptg_checker
    import ptg_pkg::*;
#(
    parameter int unsigned PIX_W  = 12,
    parameter int unsigned LINE_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic [PIX_W-1:0]  pix_cnt_o,
    input logic [LINE_W-1:0] line_cnt_o,
    input logic              vs_o,
    input logic              hs_o,
    input logic              de_o,
    input logic [PIX_W-1:0]  sh_hs_on,
    input logic [PIX_W-1:0]  sh_hs_off,
    input logic              sh_pol_vs,
    input logic              sh_pol_hs,
    input logic              sh_pol_de,
    input logic              sh_de_in_vs,
    input vs_state_e         vs_state
);

    logic rst_q = 1'b0;

    always @(posedge clk) begin
        rst_q <= rst;
    end

    // R9: the cycle after a reset edge shows every output idle
    always @(posedge clk) begin
        if (rst_q) begin
            assert_reset_idle_R9: assert ((vs_o == !sh_pol_vs) && (hs_o == !sh_pol_hs) && (de_o == !sh_pol_de))
                else $error("outputs not idle after reset");
        end
    end

    assert_pix_step_R1: assert property (@(posedge clk) disable iff (rst || rst_q)
        (pix_cnt_o != '0) |-> (pix_cnt_o == PIX_W'($past(pix_cnt_o) + 1'b1)))
        else $error("pixel count skipped");

    assert_line_hold_R1: assert property (@(posedge clk) disable iff (rst || rst_q)
        (pix_cnt_o != '0) |-> $stable(line_cnt_o))
        else $error("line count moved inside a line");

    assert_hs_window_R3: assert property (@(posedge clk) disable iff (rst || rst_q)
        (hs_o == $past(sh_pol_hs)) == (($past(pix_cnt_o) >= $past(sh_hs_on)) && ($past(pix_cnt_o) < $past(sh_hs_off))))
        else $error("hsync does not match window");

    assert_vs_line0_R4: assert property (@(posedge clk) disable iff (rst || rst_q)
        $rose(vs_state == VS_ACTIVE) |-> (line_cnt_o == '0))
        else $error("vsync started outside line 0");

    assert_de_blank_R7: assert property (@(posedge clk) disable iff (rst || rst_q)
        (!$past(sh_de_in_vs) && (vs_o == $past(sh_pol_vs))) |-> (de_o != $past(sh_pol_de)))
        else $error("data enable active during vsync");

endmodule

bind panel_timing_gen ptg_checker #(
    .PIX_W (PIX_W),
    .LINE_W(LINE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pix_cnt_o  (pix_cnt_o),
    .line_cnt_o (line_cnt_o),
    .vs_o       (vs_o),
    .hs_o       (hs_o),
    .de_o       (de_o),
    .sh_hs_on   (sh_hs_on),
    .sh_hs_off  (sh_hs_off),
    .sh_pol_vs  (sh_pol_vs),
    .sh_pol_hs  (sh_pol_hs),
    .sh_pol_de  (sh_pol_de),
    .sh_de_in_vs(sh_de_in_vs),
    .vs_state   (vs_state)
);

// File: tb/sim_panel_timing_gen.sv
module sim_panel_timing_gen;

    localparam int PW = 12;
    localparam int LW = 11;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1;
    logic [PW-1:0] cfg_h_total = PW'(20);
    logic [LW-1:0] cfg_v_total = LW'(8);
    logic [PW-1:0] cfg_hs_on = '0, cfg_hs_off = '0, cfg_vs_on_pix = '0;
    logic [LW-1:0] cfg_vs_off_line = '0;
    logic [PW-1:0] cfg_vs_off_pix = '0, cfg_de_on = '0, cfg_de_off = '0;
    logic          cfg_pol_vs = 1'b1, cfg_pol_hs = 1'b1, cfg_pol_de = 1'b1, cfg_de_in_vs = 1'b1;
    logic          vs_o, hs_o, de_o;
    logic [PW-1:0] pix_cnt_o;
    logic [LW-1:0] line_cnt_o;

    panel_timing_gen #(.PIX_W(PW), .LINE_W(LW)) u0 (
        .clk(clk), .rst(rst),
        .cfg_h_total(cfg_h_total), .cfg_v_total(cfg_v_total),
        .cfg_hs_on(cfg_hs_on), .cfg_hs_off(cfg_hs_off),
        .cfg_vs_on_pix(cfg_vs_on_pix), .cfg_vs_off_line(cfg_vs_off_line),
        .cfg_vs_off_pix(cfg_vs_off_pix),
        .cfg_de_on(cfg_de_on), .cfg_de_off(cfg_de_off),
        .cfg_pol_vs(cfg_pol_vs), .cfg_pol_hs(cfg_pol_hs), .cfg_pol_de(cfg_pol_de),
        .cfg_de_in_vs(cfg_de_in_vs),
        .vs_o(vs_o), .hs_o(hs_o), .de_o(de_o),
        .pix_cnt_o(pix_cnt_o), .line_cnt_o(line_cnt_o)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Bench model: position and the configuration governing the frame
    int m_pix, m_line;
    int a_ht, a_vt, a_hson, a_hsoff, a_von, a_vel, a_vep, a_deon, a_deoff;
    bit a_pv, a_ph, a_pd, a_dvs;

    // Values written mid-frame by the frame-boundary test
    int p_ht, p_vt, p_hson, p_hsoff, p_deon, p_deoff;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int ht, input int vt, input int hson, input int hsoff,
                           input int von, input int vel, input int vep,
                           input int deon, input int deoff,
                           input bit pv, input bit ph, input bit pd, input bit dvs);
        cfg_h_total = PW'(ht); cfg_v_total = LW'(vt);
        cfg_hs_on = PW'(hson); cfg_hs_off = PW'(hsoff);
        cfg_vs_on_pix = PW'(von); cfg_vs_off_line = LW'(vel); cfg_vs_off_pix = PW'(vep);
        cfg_de_on = PW'(deon); cfg_de_off = PW'(deoff);
        cfg_pol_vs = pv; cfg_pol_hs = ph; cfg_pol_de = pd; cfg_de_in_vs = dvs;
    endtask

    task automatic latch_model();
        a_ht = int'(cfg_h_total); a_vt = int'(cfg_v_total);
        a_hson = int'(cfg_hs_on); a_hsoff = int'(cfg_hs_off);
        a_von = int'(cfg_vs_on_pix); a_vel = int'(cfg_vs_off_line); a_vep = int'(cfg_vs_off_pix);
        a_deon = int'(cfg_de_on); a_deoff = int'(cfg_de_off);
        a_pv = cfg_pol_vs; a_ph = cfg_pol_hs; a_pd = cfg_pol_de; a_dvs = cfg_de_in_vs;
    endtask

    // Reset for two edges; returns at the falling edge right after release
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pix = 0;
        m_line = 0;
        latch_model();
    endtask

    function automatic bit in_win(input int p, input int on, input int off);
        return (p >= on) && (p < off);
    endfunction

    function automatic bit vs_region(input int p, input int l);
        bit after_start, before_end;
        after_start = (l > 0) || (p >= a_von);
        before_end  = (l < a_vel) || ((l == a_vel) && (p < a_vep));
        return after_start && before_end;
    endfunction

    // Runs n cycles comparing counts and strobes against the model;
    // at cycle chg_at the pending configuration is written (at a falling edge)
    task automatic run_cycles(input int n, input int chg_at,
                              input string t_vs, input string t_hs, input string t_de);
        int errs[4];
        int fa[4];
        int fe[4];
        for (int k = 0; k < 4; k++) begin
            errs[k] = 0; fa[k] = 0; fe[k] = 0;
        end
        for (int i = 0; i < n; i++) begin
            bit xv, xh, xd, av, ah, ad;
            if (i == chg_at) begin
                cfg_h_total = PW'(p_ht); cfg_v_total = LW'(p_vt);
                cfg_hs_on = PW'(p_hson); cfg_hs_off = PW'(p_hsoff);
                cfg_de_on = PW'(p_deon); cfg_de_off = PW'(p_deoff);
            end
            av = vs_region(m_pix, m_line);
            ah = in_win(m_pix, a_hson, a_hsoff);
            ad = in_win(m_pix, a_deon, a_deoff) && (a_dvs || !av);
            xv = a_pv ? av : !av;
            xh = a_ph ? ah : !ah;
            xd = a_pd ? ad : !ad;
            @(posedge clk);
            if (m_pix >= a_ht - 1) begin
                m_pix = 0;
                m_line = (m_line >= a_vt - 1) ? 0 : m_line + 1;
            end else begin
                m_pix++;
            end
            if (m_pix == 0 && m_line == 0) latch_model();
            @(negedge clk);
            if (int'(pix_cnt_o) != m_pix || int'(line_cnt_o) != m_line) begin
                if (errs[0] == 0) begin
                    fa[0] = int'(line_cnt_o) * 10000 + int'(pix_cnt_o);
                    fe[0] = m_line * 10000 + m_pix;
                end
                errs[0]++;
            end
            if (vs_o != xv) begin
                if (errs[1] == 0) begin fa[1] = int'(vs_o); fe[1] = int'(xv); end
                errs[1]++;
            end
            if (hs_o != xh) begin
                if (errs[2] == 0) begin fa[2] = int'(hs_o); fe[2] = int'(xh); end
                errs[2]++;
            end
            if (de_o != xd) begin
                if (errs[3] == 0) begin fa[3] = int'(de_o); fe[3] = int'(xd); end
                errs[3]++;
            end
        end
        chk(errs[0] == 0, "R1 position (line*10000+pix)", fa[0], fe[0]);
        chk(errs[1] == 0, {t_vs, " vsync, R8 one-clock delay"}, fa[1], fe[1]);
        chk(errs[2] == 0, {t_hs, " hsync, R8 one-clock delay"}, fa[2], fe[2]);
        chk(errs[3] == 0, {t_de, " data enable, R8 one-clock delay"}, fa[3], fe[3]);
    endtask

    // R9 reset state with two polarity mixes, then R8 first registered value
    task automatic t_reset();
        set_cfg(20, 8, 0, 3, 10, 2, 6, 6, 18, 1'b1, 1'b0, 1'b1, 1'b1);
        do_reset();
        chk(pix_cnt_o == '0 && line_cnt_o == '0, "R9 counts at reset", int'(pix_cnt_o), 0);
        chk(vs_o == 1'b0, "R9 vsync idle (pol 1)", int'(vs_o), 0);
        chk(hs_o == 1'b1, "R9 hsync idle (pol 0)", int'(hs_o), 1);
        chk(de_o == 1'b0, "R9 data enable idle (pol 1)", int'(de_o), 0);
        @(posedge clk);
        @(negedge clk);
        chk(hs_o == 1'b0, "R8 hsync shows pixel 0 after one clock", int'(hs_o), 0);
        chk(pix_cnt_o == PW'(1), "R1 pixel count steps", int'(pix_cnt_o), 1);
        set_cfg(20, 8, 2, 5, 10, 2, 6, 6, 18, 1'b0, 1'b1, 1'b0, 1'b1);
        do_reset();
        chk(vs_o == 1'b1 && hs_o == 1'b0 && de_o == 1'b1, "R9 idle levels (pol 0,1,0)",
            int'({vs_o, hs_o, de_o}), 5);
    endtask

    task automatic t_basic();
        set_cfg(20, 8, 2, 5, 10, 2, 6, 6, 18, 1'b1, 1'b1, 1'b1, 1'b1);
        do_reset();
        run_cycles(330, -1, "R4", "R3", "R6 R7 allowed");
    endtask

    task automatic t_polarity();
        set_cfg(20, 8, 2, 5, 10, 2, 6, 6, 18, 1'b0, 1'b0, 1'b0, 1'b1);
        do_reset();
        run_cycles(330, -1, "R2 R4", "R2 R3", "R2 R6");
        set_cfg(20, 8, 2, 5, 10, 2, 6, 6, 18, 1'b1, 1'b0, 1'b0, 1'b1);
        do_reset();
        run_cycles(170, -1, "R2 mixed", "R2 mixed", "R2 mixed");
    endtask

    task automatic t_de_blank();
        set_cfg(20, 8, 2, 5, 10, 2, 6, 6, 18, 1'b1, 1'b1, 1'b1, 1'b0);
        do_reset();
        run_cycles(330, -1, "R4", "R3", "R7 blanked");
        set_cfg(20, 8, 2, 5, 4, 1, 12, 0, 20, 1'b0, 1'b1, 1'b0, 1'b0);
        do_reset();
        run_cycles(330, -1, "R4", "R3", "R7 blanked inverted");
    endtask

    task automatic t_empty();
        set_cfg(20, 8, 7, 7, 5, 0, 5, 9, 9, 1'b1, 1'b1, 1'b1, 1'b1);
        do_reset();
        run_cycles(330, -1, "R5 empty", "R3 empty", "R6 empty");
        set_cfg(20, 8, 9, 4, 8, 0, 3, 15, 2, 1'b1, 1'b1, 1'b1, 1'b1);
        do_reset();
        run_cycles(170, -1, "R5 reversed", "R3 reversed", "R6 reversed");
    endtask

    task automatic t_vs_shapes();
        set_cfg(20, 8, 2, 5, 3, 0, 12, 6, 18, 1'b1, 1'b1, 1'b1, 1'b0);
        do_reset();
        run_cycles(330, -1, "R5 same line", "R3", "R7");
        set_cfg(20, 8, 2, 5, 0, 1, 0, 0, 10, 1'b1, 1'b1, 1'b1, 1'b0);
        do_reset();
        run_cycles(330, -1, "R4 start at pixel 0", "R3", "R7");
    endtask

    task automatic t_frame_update();
        set_cfg(20, 8, 2, 5, 10, 2, 6, 6, 18, 1'b1, 1'b1, 1'b1, 1'b1);
        p_ht = 16; p_vt = 6; p_hson = 10; p_hsoff = 14; p_deon = 4; p_deoff = 12;
        do_reset();
        run_cycles(420, 50, "R10", "R10", "R10");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_polarity();
        t_de_blank();
        t_empty();
        t_vs_shapes();
        t_frame_update();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule